// File: doc/BRIEF.md
# Host Frame Injection Framer

This block moves one frame from a host into a switch injection queue. The host offers the frame as a byte length, a fixed-length internal header and a set of 32-bit payload words. The payload words are read on demand through an index and a combinational data input. The block turns the frame into a stream of word writes on a port with a control/data select. That stream is:

- a start control word,
- the header words,
- the payload words,
- zero padding up to the minimum Ethernet size,
- an end control word that carries the count of valid bytes in the last word,
- a zero placeholder for the CRC.

Before it accepts a request, the block checks the queue status. If the queue has no room, or its fill level has reached the watermark, the request is refused right away. While a frame is being written, `busy` is high and further requests are ignored.

Top module: `inj_framer`

## Requirements
- R1: A request made while idle is accepted only when `q_ready`=1 and `q_wmark`=0. Otherwise `refused` pulses high for exactly the one cycle after the request, and no write occurs.
- R2: The first write after acceptance happens in the cycle after the accepting edge. It is a control write (`wr_ctrl`=1) of value 0x11. The control layout is: bit 0 start, bit 1 end, bits 3:2 valid bytes, bits 7:4 gap size (here 1). All other bits are zero.
- R3: Next come HDR_WORDS data writes (`wr_ctrl`=0) carrying the header words, with word 0 taken from `req_hdr[31:0]` first.
- R4: Next come ceil(len/4) data writes carrying `dat_word` for `dat_idx` = 0, 1, 2 and so on in order. A length of 0 produces no payload writes.
- R5: Zero data words follow until at least 15 words (60 bytes) of payload plus padding have been written. No padding is added when the payload already has 15 or more words.
- R6: The end control write has bit 1 set, gap size 1 and bit 0 clear. Its valid-bytes field is 0 when len < 60, and len mod 4 otherwise.
- R7: The end control write is followed by exactly one zero data write, the CRC placeholder. After it, no write occurs until a new request is accepted.
- R8: `busy` is high in exactly the cycles from the start control write through the CRC placeholder write. A request raised while busy has no effect on the frame in progress.
- R9: After reset, `busy`, `wr_en` and `refused` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request to inject one frame |
| req_len | input | LEN_W | Frame length in bytes |
| req_hdr | input | 32*HDR_WORDS | Internal frame header, word 0 in the low bits |
| q_ready | input | 1 | Queue ready status |
| q_wmark | input | 1 | Queue watermark-reached status |
| busy | output | 1 | Frame write in progress |
| refused | output | 1 | One-cycle pulse: request refused because of queue status |
| dat_idx | output | LEN_W | Index of the payload word wanted |
| dat_word | input | 32 | Payload word at `dat_idx`, combinational from the host |
| wr_en | output | 1 | Queue word write strobe |
| wr_ctrl | output | 1 | 1 = control word, 0 = data word |
| wr_data | output | 32 | Word written to the queue |

## Verification
The assertions assume that `q_ready` and `q_wmark` are stable across the request edge. The refusal check relates `refused` to the status one cycle earlier. They also assume that the host never pokes the write port and that no control word other than start and end is produced. The bench drives every input at the falling edge, so all inputs are steady at each rising edge. It drives the status inputs only while the block is idle. It holds `req_len` and `req_hdr` steady at acceptance, and changes them only in its deliberate mid-frame request.

// File: rtl/inj_pkg.sv
package inj_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_HDR,
        ST_DAT,
        ST_PAD,
        ST_EOF,
        ST_CRC
    } inj_state_e;

    // Control word layout: gap[7:4], valid bytes[3:2], end[1], start[0]
    typedef struct packed {
        logic [3:0] gap;
        logic [1:0] vld;
        logic       eof;
        logic       sof;
    } ctrl_t;

    localparam logic [3:0] GAP_SIZE = 4'd1;

    function automatic word_t pack_ctrl(input ctrl_t c);
        return {{(WORD_W-8){1'b0}}, c};
    endfunction
endpackage

// File: rtl/inj_admit.sv
module inj_admit (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic idle,
    input  logic q_ready,
    input  logic q_wmark,
    output logic accept,
    output logic refused
);
    logic room_ok;

    assign room_ok = q_ready && !q_wmark;
    assign accept  = req && idle && room_ok;

    always_ff @(posedge clk) begin
        if (rst) refused <= 1'b0;
        else     refused <= req && idle && !room_ok;
    end
endmodule

// File: rtl/inj_ctrl_enc.sv
module inj_ctrl_enc
    import inj_pkg::*;
(
    input  logic       is_end,
    input  logic [1:0] vld,
    output word_t      word
);
    ctrl_t c;

    always_comb begin
        c.gap = GAP_SIZE;
        c.sof = !is_end;
        c.eof = is_end;
        c.vld = is_end ? vld : 2'd0;
        word  = pack_ctrl(c);
    end
endmodule

// File: rtl/inj_framer.sv
module inj_framer
    import inj_pkg::*;
#(
    parameter int HDR_WORDS = 4,
    parameter int LEN_W     = 14,
    parameter int MIN_BYTES = 60
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req,
    input  logic [LEN_W-1:0]        req_len,
    input  logic [32*HDR_WORDS-1:0] req_hdr,
    input  logic                    q_ready,
    input  logic                    q_wmark,
    output logic                    busy,
    output logic                    refused,
    output logic [LEN_W-1:0]        dat_idx,
    input  logic [31:0]             dat_word,
    output logic                    wr_en,
    output logic                    wr_ctrl,
    output logic [31:0]             wr_data
);
    localparam int HIDX_W = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;
    localparam logic [LEN_W-1:0] HDR_LAST  = LEN_W'(HDR_WORDS - 1);
    localparam logic [LEN_W-1:0] MIN_WORDS = LEN_W'((MIN_BYTES + 3) / 4);
    localparam logic [LEN_W-1:0] MIN_LEN   = LEN_W'(MIN_BYTES);

    inj_state_e       state, state_n;
    logic [LEN_W-1:0] cnt, cnt_n;
    logic [LEN_W-1:0] nwords_q;
    logic [1:0]       vld_q;
    word_t            hdr_q [HDR_WORDS];
    logic             accept;
    logic [LEN_W:0]   len_round;
    word_t            ctrl_word;

    inj_admit u_admit (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .idle    (state == ST_IDLE),
        .q_ready (q_ready),
        .q_wmark (q_wmark),
        .accept  (accept),
        .refused (refused)
    );

    inj_ctrl_enc u_enc (
        .is_end (state == ST_EOF),
        .vld    (vld_q),
        .word   (ctrl_word)
    );

    assign len_round = {1'b0, req_len} + (LEN_W+1)'(3);

    // State sequencing
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE: if (accept) begin
                state_n = ST_SOF;
                cnt_n   = '0;
            end
            ST_SOF: state_n = ST_HDR;
            ST_HDR: begin
                if (cnt == HDR_LAST) begin
                    cnt_n = '0;
                    if (nwords_q != '0)       state_n = ST_DAT;
                    else if (MIN_WORDS != '0) state_n = ST_PAD;
                    else                      state_n = ST_EOF;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_DAT: begin
                cnt_n = cnt + 1'b1;
                if (cnt == nwords_q - 1'b1)
                    state_n = (nwords_q < MIN_WORDS) ? ST_PAD : ST_EOF;
            end
            ST_PAD: begin
                cnt_n = cnt + 1'b1;
                if (cnt >= MIN_WORDS - 1'b1) state_n = ST_EOF;
            end
            ST_EOF: state_n = ST_CRC;
            ST_CRC: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            nwords_q <= '0;
            vld_q    <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (accept) begin
                nwords_q <= len_round[LEN_W:2];
                vld_q    <= (req_len < MIN_LEN) ? 2'd0 : req_len[1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < HDR_WORDS; i++)
                hdr_q[i] <= req_hdr[32*i +: 32];
        end
    end

    // Write port
    always_comb begin
        wr_en   = 1'b1;
        wr_ctrl = 1'b0;
        wr_data = '0;
        unique case (state)
            ST_IDLE: wr_en = 1'b0;
            ST_SOF, ST_EOF: begin
                wr_ctrl = 1'b1;
                wr_data = ctrl_word;
            end
            ST_HDR:  wr_data = hdr_q[cnt[HIDX_W-1:0]];
            ST_DAT:  wr_data = dat_word;
            default: wr_data = '0;
        endcase
    end

    assign busy    = (state != ST_IDLE);
    assign dat_idx = cnt;
endmodule

// File: rtl/inj_framer_chk.sv
module inj_framer_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        refused,
    input logic        q_ready,
    input logic        q_wmark,
    input logic        wr_en,
    input logic        wr_ctrl,
    input logic [31:0] wr_data
);
    logic eof_wr;
    assign eof_wr = wr_en && wr_ctrl && wr_data[1];

    AST_REFUSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        refused |-> $past(!q_ready || q_wmark)); // R1
    AST_REFUSE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        refused |-> !wr_en); // R1
    AST_FIRST_IS_SOF: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (wr_ctrl && wr_data == 32'h11)); // R2
    AST_CTRL_GAP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctrl) |-> (wr_data[7:4] == 4'd1 && wr_data[31:8] == '0)); // R6
    AST_CRC_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
        eof_wr |=> (wr_en && !wr_ctrl && wr_data == '0)); // R7
    AST_IDLE_AFTER_CRC: assert property (@(posedge clk) disable iff (rst)
        eof_wr |-> ##2 !busy); // R8
    AST_BUSY_WRITES: assert property (@(posedge clk) disable iff (rst)
        busy == wr_en); // R8
endmodule

bind inj_framer inj_framer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .refused (refused),
    .q_ready (q_ready),
    .q_wmark (q_wmark),
    .wr_en   (wr_en),
    .wr_ctrl (wr_ctrl),
    .wr_data (wr_data)
);

// File: tb/inj_framer_bench.sv
module inj_framer_bench;
    localparam int HW = 4;
    localparam int LW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic [32*HW-1:0] req_hdr = '0;
    logic          q_ready = 1'b1;
    logic          q_wmark = 1'b0;
    logic          busy, refused, wr_en, wr_ctrl;
    logic [LW-1:0] dat_idx;
    logic [31:0]   dat_word, wr_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    assign dat_word = 32'hA500_0000 | 32'(dat_idx);

    inj_framer #(.HDR_WORDS(HW), .LEN_W(LW), .MIN_BYTES(60)) u_inj_framer (
        .clk(clk), .rst(rst), .req(req), .req_len(req_len), .req_hdr(req_hdr),
        .q_ready(q_ready), .q_wmark(q_wmark), .busy(busy), .refused(refused),
        .dat_idx(dat_idx), .dat_word(dat_word), .wr_en(wr_en),
        .wr_ctrl(wr_ctrl), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!busy && !wr_en && !refused, "R9", "reset outputs",
              {busy, wr_en, refused}, 0);
    endtask

    // Runs one frame, optionally poking a second request mid-frame
    task automatic t_frame(input int len, input bit poke);
        logic [32:0] got [0:299];
        logic [32:0] exp [0:299];
        int n = 0, e = 0, nw, first_dat, vld;
        bit busy_ok = 1, sof_ok, hdr_ok = 1, dat_ok = 1, pad_ok = 1, seq_ok = 1;
        for (int i = 0; i < HW; i++) req_hdr[32*i +: 32] = 32'hC0DE_0000 + 32'(i) + 32'(len << 8);
        nw = (len + 3) / 4;
        vld = (len < 60) ? 0 : len % 4;
        exp[e++] = {1'b1, 32'h11};
        for (int i = 0; i < HW; i++) exp[e++] = {1'b0, 32'hC0DE_0000 + 32'(i) + 32'(len << 8)};
        first_dat = e;
        for (int i = 0; i < nw; i++) exp[e++] = {1'b0, 32'hA500_0000 | 32'(i)};
        for (int i = nw; i < 15; i++) exp[e++] = {1'b0, 32'h0};
        exp[e++] = {1'b1, 32'h12 | 32'(vld << 2)};
        exp[e++] = {1'b0, 32'h0};
        @(negedge clk);
        req_len = LW'(len);
        req = 1'b1;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            req = 1'b0;
            if (poke && c == 4) begin
                req = 1'b1;
                req_len = LW'(len + 40);
            end
            if (busy != wr_en) busy_ok = 0;
            if (!busy) break;
            if (n < 300) got[n] = {wr_ctrl, wr_data};
            n++;
        end
        req = 1'b0;
        check(n == e, "R5", $sformatf("len %0d write count", len), n, e);
        sof_ok = (got[0] == exp[0]);
        check(sof_ok, "R2", "start control word", got[0], exp[0]);
        for (int i = 1; i <= HW && i < n; i++) if (got[i] != exp[i]) hdr_ok = 0;
        check(hdr_ok, "R3", "header words", got[1], exp[1]);
        for (int i = first_dat; i < first_dat + nw && i < n; i++) if (got[i] != exp[i]) dat_ok = 0;
        check(dat_ok, "R4", $sformatf("len %0d payload", len), got[first_dat], exp[first_dat]);
        for (int i = first_dat + nw; i < e - 2 && i < n; i++) if (got[i] != exp[i]) pad_ok = 0;
        check(pad_ok, "R5", $sformatf("len %0d padding", len), n, e);
        if (n == e) begin
            check(got[e-2] == exp[e-2], "R6", $sformatf("len %0d end control", len), got[e-2], exp[e-2]);
            check(got[e-1] == exp[e-1], "R7", "CRC placeholder", got[e-1], exp[e-1]);
        end else begin
            for (int i = 0; i < n && i < e; i++) if (got[i] != exp[i]) seq_ok = 0;
            check(0, "R6", "sequence length mismatch", n, e);
        end
        check(busy_ok, "R8", "busy matches write window", busy_ok, 1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check(!wr_en && !busy, poke ? "R8" : "R7", "idle after frame", wr_en, 0);
        end
    endtask

    task automatic t_refuse(input bit rdy, input bit wm);
        @(negedge clk);
        q_ready = rdy;
        q_wmark = wm;
        req_len = 14'd64;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(refused && !wr_en && !busy, "R1", $sformatf("refuse rdy=%0d wm=%0d", rdy, wm),
              {refused, wr_en, busy}, 3'b100);
        @(negedge clk);
        check(!refused && !wr_en && !busy, "R1", "refuse pulse one cycle",
              {refused, wr_en, busy}, 0);
        q_ready = 1'b1;
        q_wmark = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_frame(0, 0);
        t_frame(1, 0);
        t_frame(10, 0);
        t_frame(59, 0);
        t_frame(60, 0);
        t_frame(61, 0);
        t_frame(63, 0);
        t_frame(64, 0);
        t_refuse(0, 0);
        t_refuse(1, 1);
        t_refuse(0, 1);
        t_frame(70, 1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule